// File: doc/BRIEF.md
# Tilt Orientation Classifier

This block takes a stream of signed gravity samples for three axes and works out how a handheld device is held. The in-plane reading is one of four poses: portrait upright, portrait inverted, landscape right or landscape left. The Z sign separately marks whether the screen faces up (front) or down (back). A sample is taken on any clock edge where `smp_valid` is high. All outputs are registered, so a sample's effect shows on the outputs right after the edge that took it.

Hysteresis keeps the portrait/landscape decision from chattering near the diagonal. The angle used is the elevation of the in-plane gravity vector above the X axis. A portrait reading turns to landscape only once that angle falls below about 31°. A landscape reading turns to portrait only once it rises above about 59°. When the device lies close to flat, the in-plane vector is too short to trust, so the in-plane pose is frozen and a lockout bit is raised.

A new pose must be seen on several samples in a row before it is reported. A sticky change flag then tells the host that the status is new, and the host clears it with a read strobe. With the default parameters, 1 g equals 1024 counts (12-bit samples at ±2 g).

Top module: `tilt_orient`

## Requirements
- R1: After reset the outputs are `pl_o`=0 (portrait upright), `back_o`=0, `lock_o`=0 and `chg_o`=0.
- R2: In portrait, or when entering it, the pose is upright (code 0) for a negative Y sample and inverted (code 1) for a Y sample of zero or more.
- R3: In landscape, or when entering it, the pose is landscape left (code 3) for an X sample of zero or more and landscape right (code 2) for a negative X sample.
- R4: A portrait pose moves to landscape only when |Y|·256 < |X|·154, which is about 31°.
- R5: A landscape pose moves to portrait only when |Y|·256 > |X|·426, which is about 59°. Between the two bounds the current category is kept.
- R6: A sample is locked when (X²+Y²)·1024 < Z²·315, which is a tilt from flat below about 29°. The lockout bit then shows 1 after that sample, with no debounce, and the in-plane pose does not change. For an unlocked sample the bit shows 0.
- R7: The back bit candidate is 1 for a negative Z sample and 0 otherwise. It is evaluated even during lockout and is debounced together with the pose.
- R8: A candidate {pose, back} that differs from the reported one is reported on the edge of the DB_CNT-th consecutive valid sample that carries it (default 4). A different candidate in between restarts the count. A sample matching the reported value cancels the count.
- R9: `chg_o` goes to 1 on the edge where the reported value changes. It stays at 1 until an edge with `rd_ack` high. If a change and `rd_ack` fall on the same edge, the flag is set.
- R10: Edges with `smp_valid` low leave pose, back, lockout and the debounce progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Take the X/Y/Z sample on this edge |
| ax | input | 12 | Signed X gravity sample |
| ay | input | 12 | Signed Y gravity sample |
| az | input | 12 | Signed Z gravity sample |
| rd_ack | input | 1 | Status read strobe that clears the change flag |
| pl_o | output | 2 | Reported pose: 0 upright, 1 inverted, 2 landscape right, 3 landscape left |
| back_o | output | 1 | Reported face: 1 back (Z negative), 0 front |
| lock_o | output | 1 | Last valid sample was locked (near flat) |
| chg_o | output | 1 | Sticky flag: reported pose or face changed |

## Verification
The assertions check the temporal rules on every cycle. Outputs hold on idle edges. The pose stays frozen while a locked sample is taken. The change flag only rises after a valid sample and is present on every reported change. A read with no concurrent change clears it. Which pose a given vector yields depends on the hysteresis bounds, the lockout cone and the exact number of samples needed to commit. Only the bench's scenarios can show these. It sweeps a grid of X, Y and Z values against an arithmetic model. It also walks directed vectors that sit just inside and just outside each trip boundary.

// File: rtl/tilt_pkg.sv
package tilt_pkg;

    typedef enum logic [1:0] {
        PL_PU = 2'd0,
        PL_PD = 2'd1,
        PL_LR = 2'd2,
        PL_LL = 2'd3
    } pl_e;

    typedef struct packed {
        pl_e  pl;
        logic back;
    } orient_t;

    localparam orient_t ORIENT_RESET = '{pl: PL_PU, back: 1'b0};

endpackage

// File: rtl/tilt_classify.sv
module tilt_classify
    import tilt_pkg::*;
#(
    parameter int AW    = 12,
    parameter int KW    = 10,
    parameter int FRAC  = 8,
    parameter int K_P2L = 154,
    parameter int K_L2P = 426
) (
    input  logic signed [AW-1:0] ax,
    input  logic signed [AW-1:0] ay,
    input  pl_e                  cur,
    output pl_e                  cand
);
    localparam int PW = AW + KW + 1;

    logic [AW-1:0] xa, ya;
    logic [PW-1:0] y_sc, x_p2l, x_l2p;
    logic          in_land, go_land;

    always_comb begin
        xa      = ax[AW-1] ? $unsigned(-ax) : $unsigned(ax);
        ya      = ay[AW-1] ? $unsigned(-ay) : $unsigned(ay);
        y_sc    = PW'(ya) << FRAC;
        x_p2l   = PW'(xa) * PW'(K_P2L);
        x_l2p   = PW'(xa) * PW'(K_L2P);
        in_land = cur[1];
        // Trip point depends on the category now reported
        if (in_land) go_land = !(y_sc > x_l2p);
        else         go_land = (y_sc < x_p2l);
        if (go_land) cand = ax[AW-1] ? PL_LR : PL_LL;
        else         cand = ay[AW-1] ? PL_PU : PL_PD;
    end
endmodule

// File: rtl/tilt_lock.sv
module tilt_lock #(
    parameter int AW     = 12,
    parameter int LFRAC  = 10,
    parameter int K_LOCK = 315
) (
    input  logic signed [AW-1:0] ax,
    input  logic signed [AW-1:0] ay,
    input  logic signed [AW-1:0] az,
    output logic                 locked
);
    localparam int SW = 2 * AW + 2 + LFRAC;

    logic [AW-1:0] xa, ya, za;
    logic [SW-1:0] xy_sq, z_sq, lhs, rhs;

    always_comb begin
        xa     = ax[AW-1] ? $unsigned(-ax) : $unsigned(ax);
        ya     = ay[AW-1] ? $unsigned(-ay) : $unsigned(ay);
        za     = az[AW-1] ? $unsigned(-az) : $unsigned(az);
        xy_sq  = SW'(xa) * SW'(xa) + SW'(ya) * SW'(ya);
        z_sq   = SW'(za) * SW'(za);
        lhs    = xy_sq << LFRAC;
        rhs    = z_sq * SW'(K_LOCK);
        locked = (lhs < rhs);
    end
endmodule

// File: rtl/tilt_orient.sv
module tilt_orient
    import tilt_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DB_CNT = 4,
    parameter int KW     = 10,
    parameter int FRAC   = 8,
    parameter int K_P2L  = 154,
    parameter int K_L2P  = 426,
    parameter int LFRAC  = 10,
    parameter int K_LOCK = 315
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [AW-1:0] ax,
    input  logic signed [AW-1:0] ay,
    input  logic signed [AW-1:0] az,
    input  logic                 rd_ack,
    output logic [1:0]           pl_o,
    output logic                 back_o,
    output logic                 lock_o,
    output logic                 chg_o
);
    localparam int CW = $clog2(DB_CNT + 1);

    typedef struct packed {
        orient_t         rep;
        orient_t         pend;
        logic [CW-1:0]   cnt;
        logic            lock;
        logic            chg;
    } state_t;

    state_t  st_d, st_q;
    pl_e     cls_pl;
    logic    lock_w;
    orient_t cand;
    logic    commit;

    tilt_classify #(
        .AW(AW), .KW(KW), .FRAC(FRAC), .K_P2L(K_P2L), .K_L2P(K_L2P)
    ) u_cls (
        .ax(ax), .ay(ay), .cur(st_q.rep.pl), .cand(cls_pl)
    );

    tilt_lock #(
        .AW(AW), .LFRAC(LFRAC), .K_LOCK(K_LOCK)
    ) u_lock (
        .ax(ax), .ay(ay), .az(az), .locked(lock_w)
    );

    always_comb begin
        st_d      = st_q;
        commit    = 1'b0;
        cand.pl   = lock_w ? st_q.rep.pl : cls_pl;
        cand.back = az[AW-1];
        if (smp_valid) begin
            st_d.lock = lock_w;
            if (cand == st_q.rep) begin
                st_d.cnt = '0;
            end else begin
                if (st_q.cnt != '0 && cand == st_q.pend) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end else begin
                    st_d.pend = cand;
                    st_d.cnt  = CW'(1);
                end
                if (st_d.cnt == CW'(DB_CNT)) begin
                    st_d.rep = cand;
                    st_d.cnt = '0;
                    commit   = 1'b1;
                end
            end
        end
        if (commit)      st_d.chg = 1'b1;
        else if (rd_ack) st_d.chg = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rep  <= ORIENT_RESET;
            st_q.pend <= ORIENT_RESET;
            st_q.cnt  <= '0;
            st_q.lock <= 1'b0;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pl_o   = st_q.rep.pl;
    assign back_o = st_q.rep.back;
    assign lock_o = st_q.lock;
    assign chg_o  = st_q.chg;
endmodule

// File: rtl/tilt_orient_chk.sv
module tilt_orient_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic       rd_ack,
    input logic [1:0] pl_o,
    input logic       back_o,
    input logic       lock_o,
    input logic       chg_o
);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> ($stable(pl_o) && $stable(back_o) && $stable(lock_o)));

    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_valid) && lock_o) |-> $stable(pl_o));

    p_chg_on_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pl_o) || !$stable(back_o)) |-> chg_o);

    p_chg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_ack) && $stable(pl_o) && $stable(back_o)) |-> !chg_o);

    p_chg_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_o) |-> $past(smp_valid));
endmodule

bind tilt_orient tilt_orient_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rd_ack(rd_ack),
    .pl_o(pl_o), .back_o(back_o), .lock_o(lock_o), .chg_o(chg_o)
);

// File: tb/tilt_orient_test.sv
module tilt_orient_test;
    localparam int DB = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [11:0] ax = '0, ay = '0, az = '0;
    logic               rd_ack = 1'b0;
    logic [1:0]         pl_o;
    logic               back_o, lock_o, chg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int m_pl = 0, m_bk = 0, m_lk = 0, m_chg = 0;
    int p_pl = 0, p_bk = 0, m_cnt = 0;

    always #5 clk = ~clk;

    tilt_orient uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .ax(ax), .ay(ay), .az(az), .rd_ack(rd_ack),
        .pl_o(pl_o), .back_o(back_o), .lock_o(lock_o), .chg_o(chg_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint iabs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int ref_pl(input longint x, input longint y, input int cur);
        bit land;
        if (cur >= 2) land = !(iabs(y) * 256 > iabs(x) * 426);  // R5
        else          land = (iabs(y) * 256 < iabs(x) * 154);    // R4
        if (land) return (x >= 0) ? 3 : 2;                       // R3
        return (y < 0) ? 0 : 1;                                  // R2
    endfunction

    task automatic model_step(input longint x, input longint y, input longint z);
        int lk, cp, cb;
        lk = ((x * x + y * y) * 1024 < z * z * 315) ? 1 : 0;     // R6
        cp = lk ? m_pl : ref_pl(x, y, m_pl);
        cb = (z < 0) ? 1 : 0;                                    // R7
        m_lk = lk;
        if (cp == m_pl && cb == m_bk) m_cnt = 0;
        else begin
            if (m_cnt != 0 && cp == p_pl && cb == p_bk) m_cnt++;
            else begin p_pl = cp; p_bk = cb; m_cnt = 1; end
            if (m_cnt == DB) begin
                m_pl = cp; m_bk = cb; m_cnt = 0; m_chg = 1;      // R8
            end
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " pose"}, pl_o, m_pl);
        chk({tag, " back"}, back_o, m_bk);
        chk({tag, " lock"}, lock_o, m_lk);
        chk({tag, " chg"}, chg_o, m_chg);
    endtask

    task automatic send(input int x, input int y, input int z, input string tag);
        @(negedge clk);
        ax = 12'(x); ay = 12'(y); az = 12'(z); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        model_step(x, y, z);
        compare(tag);
    endtask

    task automatic ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        m_chg = 0;
        chk("R9 cleared by read", chg_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pose", pl_o, 0);
        chk("R1 back", back_o, 0);
        chk("R1 lock", lock_o, 0);
        chk("R1 chg", chg_o, 0);
        rst_n = 1'b1;

        // R3 / R8: enter landscape left, committed exactly on 4th sample
        for (int i = 0; i < 3; i++) send(1000, 0, 0, "R8 pending");
        chk("R8 not yet", pl_o, 0);
        send(1000, 0, 0, "R8 commit");
        chk("R3 left", pl_o, 3);
        chk("R9 set", chg_o, 1);
        // R10: idle edges and a changing input with valid low
        @(negedge clk);
        ax = -12'sd1000; ay = 12'sd0; az = -12'sd900;
        repeat (5) @(negedge clk);
        chk("R10 pose held", pl_o, 3);
        chk("R10 back held", back_o, 0);
        chk("R10 chg held", chg_o, 1);
        ack();

        // R5: inside the band stays landscape
        for (int i = 0; i < DB; i++) send(1000, -839, 0, "R5 band");
        chk("R5 stays landscape", pl_o, 3);
        // R5 boundary: 1000*256 > 600*426 -> portrait upright
        for (int i = 0; i < DB; i++) send(600, -1000, 0, "R5 trip");
        chk("R5 to portrait", pl_o, 0);
        // R4: inside the band stays portrait
        for (int i = 0; i < DB; i++) send(1000, -839, 0, "R4 band");
        chk("R4 stays portrait", pl_o, 0);
        // R4 boundary: 600*256 < 1000*154 -> landscape left
        for (int i = 0; i < DB; i++) send(1000, -600, 0, "R4 trip");
        chk("R4 to landscape", pl_o, 3);
        ack();

        // R8 restart: interrupted candidate does not commit
        for (int i = 0; i < 3; i++) send(-1000, 0, 0, "R8 run a");
        send(0, 1000, 0, "R8 interrupt");
        for (int i = 0; i < 3; i++) send(-1000, 0, 0, "R8 run b");
        chk("R8 restart holds", pl_o, 3);
        send(-1000, 0, 0, "R8 run b end");
        chk("R3 right", pl_o, 2);
        ack();
        // R2: inverted portrait
        for (int i = 0; i < DB; i++) send(0, 1000, 0, "R2 inverted");
        chk("R2 inverted", pl_o, 1);

        // R6 lockout and R7 back while flat
        send(300, -100, -1000, "R6 first locked");
        chk("R6 lock now", lock_o, 1);
        for (int i = 0; i < DB - 1; i++) send(300, -100, -1000, "R7 flat");
        chk("R7 back", back_o, 1);
        chk("R6 pose frozen", pl_o, 1);
        send(1000, 0, -300, "R6 unlock");
        chk("R6 lock clear", lock_o, 0);
        ack();

        // R9: commit and read on the same edge keeps flag set
        for (int i = 0; i < DB - 1; i++) send(0, -1000, 0, "R9 prep");
        @(negedge clk);
        ax = 12'sd0; ay = -12'sd1000; az = 12'sd0; smp_valid = 1'b1; rd_ack = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; rd_ack = 1'b0;
        model_step(0, -1000, 0);
        chk("R9 set wins", chg_o, 1);
        compare("R9 same edge");
        ack();

        // Grid sweep over X, Y, Z against the model (R2-R8)
        for (int zi = 0; zi < 4; zi++) begin
            for (int xi = -2048; xi < 2048; xi += 256) begin
                for (int yi = -2048; yi < 2048; yi += 256) begin
                    int zv;
                    zv = (zi == 0) ? 0 : (zi == 1) ? 900 : (zi == 2) ? -900 : 2000;
                    for (int k = 0; k < DB; k++) send(xi + 37, yi, zv, "R4 R5 R6 R7 R8 sweep");
                    if (((xi + yi) & 1024) != 0) ack();
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule